// File: doc/BRIEF.md
# Multi-Engine Reset Handshake Sequencer

This block guards a device-wide reset that spans several processing engines. A reset is only safe once every engine has parked itself: no context switch may be in flight and each engine's state must already be saved. On a start request the sequencer walks the engines one at a time, starting at index 0. For each engine it raises a request line and then waits for that engine to answer with ready.

The global reset pulse is issued only after the last engine has answered. Each wait has a cycle budget. If an engine stays silent past its budget, the sequence is abandoned. All raised requests are withdrawn and an error is reported together with the offending engine's index. The global reset is left untouched on that path, because driving it into a wedged engine can hang the whole system.

Requests are held in a bank that is updated by masked writes. One step names the set of request bits it may change and the values those bits take. Setting one engine's request and clearing all requests are two cases of that single update.

Top module: `engine_reset_sequencer`

## Requirements
- R1: While rst_n is low at a rising edge, the next cycle shows eng_req_o, gbl_rst_o, done_o, err_o and err_eng_o all zero; the block is then idle.
- R2: A start sampled high in idle raises eng_req_o bit 0 in the following cycle. Engines are requested strictly in index order. The request for engine i+1 appears one cycle after engine i's ready is accepted. Requests already raised stay high until the sequence ends.
- R3: Engine i's ready input is sampled at each of the TIMEOUT_CYC rising edges that follow the edge raising its request. A high sample at any of them is accepted, including the last one and a ready that was already high before the request.
- R4: gbl_rst_o is high for exactly one cycle, the cycle after the last engine's ready is accepted, and only while every request bit is high.
- R5: In the cycle after the global reset pulse, all request bits are low and done_o is high for one cycle; the block is then idle.
- R6: If no ready is accepted within TIMEOUT_CYC samples, then in the cycle after the last sample err_o is high for one cycle and all request bits are low. Later engines are never requested, and gbl_rst_o stays low for the whole sequence.
- R7: A start input sampled while a sequence is running, or in its final done or error cycle, has no effect on the sequence.
- R8: err_eng_o carries the binary index of the failed engine while err_o is high, and is zero whenever err_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a reset sequence (sampled in idle) |
| eng_ready_i | input | N_ENG | Per-engine ready-to-reset status |
| eng_req_o | output | N_ENG | Per-engine reset request |
| gbl_rst_o | output | 1 | One-cycle global reset pulse |
| done_o | output | 1 | One-cycle pulse: sequence completed with reset |
| err_o | output | 1 | One-cycle pulse: sequence aborted on timeout |
| err_eng_o | output | IDX_W | Index of the engine that timed out |

## Verification
A wrong engine index or a corrupted state would show at eng_req_o in the very next cycle. It appears as a request bit out of order or a bit dropped early. A counter that is off by one moves the acceptance edge or the abort edge by one cycle. It then shifts done_o or err_o, or turns a last-sample acceptance into an error. The bench predicts the exact cycle of every request rise, pulse and clear from the chosen per-engine delays. It compares these against the outputs every cycle, so any such fault shows up within one cycle of its first effect.

// File: rtl/rsq_pkg.sv
// Package: shared types for the engine reset sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package rsq_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        RS_IDLE  = 3'd0,
        RS_REQ   = 3'd1,
        RS_WAIT  = 3'd2,
        RS_FIRE  = 3'd3,
        RS_DONE  = 3'd4,
        RS_ABORT = 3'd5
    } rsq_state_e;

endpackage

// File: rtl/rsq_timeout.sv
// Module: rsq_timeout
// Counts wait cycles for the engine currently being asked to park.
// Assumes: clr_i and run_i are never high together; TIMEOUT_CYC >= 1.
// expire_o is high on the TIMEOUT_CYC-th running edge since the last clear.
module rsq_timeout #(
    parameter int TIMEOUT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic expire_o
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Advance the wait counter while running; restart it on clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag the final permitted sample
    always_comb begin
        expire_o = run_i && (cnt_q == LAST);
    end

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R3

endmodule

// File: rtl/rsq_req_bank.sv
// Module: rsq_req_bank
// Holds the per-engine reset request bits, changed only by masked update:
// a bit is rewritten from upd_val_i when its upd_mask_i bit is set and
// keeps its value otherwise.
// Assumes: the controller never sets a higher request before lower ones.
module rsq_req_bank #(
    parameter int N_ENG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ENG-1:0] upd_mask_i,
    input  logic [N_ENG-1:0] upd_val_i,
    output logic [N_ENG-1:0] req_o
);
    logic [N_ENG-1:0] req_q;

    for (genvar g = 0; g < N_ENG; g++) begin : g_bit
        // Masked update of one engine's request bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_q[g] <= 1'b0;
            end else if (upd_mask_i[g]) begin
                req_q[g] <= upd_val_i[g];
            end
        end

        if (g > 0) begin : g_ord
            AST_REQ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(req_q[g]) |-> (&req_q[g-1:0])); // R2
        end
    end

    assign req_o = req_q;

endmodule

// File: rtl/rsq_fsm.sv
// Module: rsq_fsm
// Control sequence: request each engine in index order, wait for its
// ready within the timer budget, then pulse the global reset and report
// done, or withdraw every request and report the failing engine.
// Assumes: ready_i is synchronous to clk.
module rsq_fsm
    import rsq_pkg::*;
#(
    parameter int N_ENG = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [N_ENG-1:0] ready_i,
    input  logic             expire_i,
    output logic             tmr_clr_o,
    output logic             tmr_run_o,
    output logic [N_ENG-1:0] upd_mask_o,
    output logic [N_ENG-1:0] upd_val_o,
    output logic             gbl_rst_o,
    output logic             done_o,
    output logic             err_o,
    output logic [IDX_W-1:0] err_eng_o
);
    localparam logic [IDX_W-1:0] LAST_ENG = IDX_W'(N_ENG - 1);

    rsq_state_e       st_q, st_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             cur_ready;

    // Ready status of the engine being waited on
    always_comb begin
        cur_ready = ready_i[idx_q];
    end

    // Next phase, engine index and request-bank updates
    always_comb begin
        st_d       = st_q;
        idx_d      = idx_q;
        upd_mask_o = '0;
        upd_val_o  = '0;
        tmr_clr_o  = 1'b0;
        tmr_run_o  = 1'b0;
        unique case (st_q)
            RS_IDLE: begin
                if (start_i) begin
                    st_d  = RS_REQ;
                    idx_d = '0;
                end
            end
            RS_REQ: begin
                upd_mask_o = N_ENG'(1) << idx_q;
                upd_val_o  = N_ENG'(1) << idx_q;
                tmr_clr_o  = 1'b1;
                st_d       = RS_WAIT;
            end
            RS_WAIT: begin
                tmr_run_o = 1'b1;
                if (cur_ready) begin
                    if (idx_q == LAST_ENG) begin
                        st_d = RS_FIRE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                        st_d  = RS_REQ;
                    end
                end else if (expire_i) begin
                    upd_mask_o = '1;
                    st_d       = RS_ABORT;
                end
            end
            RS_FIRE: begin
                upd_mask_o = '1;
                st_d       = RS_DONE;
            end
            RS_DONE:  st_d = RS_IDLE;
            RS_ABORT: st_d = RS_IDLE;
            default:  st_d = RS_IDLE;
        endcase
    end

    // Phase and engine index registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= RS_IDLE;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    // Status outputs decoded from the phase
    always_comb begin
        gbl_rst_o = (st_q == RS_FIRE);
        done_o    = (st_q == RS_DONE);
        err_o     = (st_q == RS_ABORT);
        err_eng_o = (st_q == RS_ABORT) ? idx_q : '0;
    end

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        gbl_rst_o |=> !gbl_rst_o); // R4
    AST_DONE_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        gbl_rst_o |=> done_o); // R5
    AST_ERR_NOT_WITH_RST: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !(done_o || gbl_rst_o)); // R6
    AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RS_WAIT && !cur_ready) |=> $stable(idx_q)); // R2

endmodule

// File: rtl/engine_reset_sequencer.sv
// Module: engine_reset_sequencer (top)
// Sequences a device-wide reset behind a per-engine request/ready
// handshake with a bounded wait per engine; the global reset is pulsed
// only when all engines are ready, and skipped on any timeout.
// Assumes: eng_ready_i is synchronous to clk; TIMEOUT_CYC is the per-
// engine budget in clock cycles (default: 700 ms at 250 MHz).
module engine_reset_sequencer #(
    parameter int N_ENG       = 4,
    parameter int TIMEOUT_CYC = 175_000_000,
    parameter int IDX_W       = (N_ENG > 1) ? $clog2(N_ENG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [N_ENG-1:0] eng_ready_i,
    output logic [N_ENG-1:0] eng_req_o,
    output logic             gbl_rst_o,
    output logic             done_o,
    output logic             err_o,
    output logic [IDX_W-1:0] err_eng_o
);
    logic             tmr_clr, tmr_run, tmr_expire;
    logic [N_ENG-1:0] upd_mask, upd_val;

    rsq_fsm #(.N_ENG(N_ENG), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .ready_i    (eng_ready_i),
        .expire_i   (tmr_expire),
        .tmr_clr_o  (tmr_clr),
        .tmr_run_o  (tmr_run),
        .upd_mask_o (upd_mask),
        .upd_val_o  (upd_val),
        .gbl_rst_o  (gbl_rst_o),
        .done_o     (done_o),
        .err_o      (err_o),
        .err_eng_o  (err_eng_o)
    );

    rsq_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (tmr_clr),
        .run_i    (tmr_run),
        .expire_o (tmr_expire)
    );

    rsq_req_bank #(.N_ENG(N_ENG)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_mask_i (upd_mask),
        .upd_val_i  (upd_val),
        .req_o      (eng_req_o)
    );

    AST_RST_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        gbl_rst_o |-> (&eng_req_o)); // R4
    AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (eng_req_o == '0)); // R5
    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (eng_req_o == '0)); // R6
    AST_ERR_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (int'(err_eng_o) < N_ENG)); // R8

endmodule

// File: tb/tb_engine_reset_sequencer.sv
module tb_engine_reset_sequencer;
    localparam int N_ENG = 3;
    localparam int TMO   = 6;
    localparam int IDX_W = 2;
    localparam int NEVER = 1000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [N_ENG-1:0] ready;
    logic [N_ENG-1:0] req;
    logic             gbl, done, err;
    logic [IDX_W-1:0] err_eng;

    int n_chk = 0;
    int n_fail = 0;
    int dly [N_ENG];
    int held [N_ENG];

    always #2 clk = ~clk;

    engine_reset_sequencer #(.N_ENG(N_ENG), .TIMEOUT_CYC(TMO), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .eng_ready_i(ready),
        .eng_req_o(req), .gbl_rst_o(gbl), .done_o(done), .err_o(err),
        .err_eng_o(err_eng)
    );

    // Engine models: ready once the request has been seen for dly cycles
    for (genvar g = 0; g < N_ENG; g++) begin : g_eng
        always @(posedge clk) held[g] <= req[g] ? ((held[g] < NEVER) ? held[g] + 1 : NEVER) : 0;
        assign ready[g] = (held[g] >= dly[g]);
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // One sequence with per-engine delays; predict every cycle arithmetically
    task automatic run_seq(input int d0, input int d1, input int d2, input bit restart, input string tg);
        int r [N_ENG];
        int fe = -1;
        int fin, clr, fire, ab, exp_mask;
        dly[0] = d0; dly[1] = d1; dly[2] = d2;
        r[0] = 1;
        for (int i = 0; i < N_ENG; i++) begin
            if (fe < 0 && dly[i] >= TMO) fe = i;
            if (i < N_ENG - 1) r[i+1] = r[i] + dly[i] + 2;
        end
        fire = r[N_ENG-1] + dly[N_ENG-1] + 1;
        ab   = (fe >= 0) ? r[fe] + TMO : -10;
        clr  = (fe >= 0) ? ab : fire + 1;
        fin  = clr;
        if (fe >= 0) fire = -10;
        @(negedge clk) start = 1'b1;
        for (int c = 0; c <= fin + 2; c++) begin
            @(negedge clk);
            if (c == 0) start = 1'b0;
            if (restart && c == 2) start = 1'b1;
            if (restart && c == 3) start = 1'b0;
            exp_mask = 0;
            for (int i = 0; i < N_ENG; i++)
                if ((fe < 0 || i <= fe) && r[i] <= c && c < clr) exp_mask |= (1 << i);
            chk(int'(req) == exp_mask, $sformatf("R2 %s req mask c=%0d", tg, c), int'(req), exp_mask);
            chk(gbl == (c == fire), $sformatf("R4 %s gbl_rst c=%0d", tg, c), int'(gbl), int'(c == fire));
            chk(done == (fe < 0 && c == clr), $sformatf("R5 %s done c=%0d", tg, c), int'(done), int'(fe < 0 && c == clr));
            chk(err == (c == ab), $sformatf("R6 %s err c=%0d", tg, c), int'(err), int'(c == ab));
            chk(int'(err_eng) == ((c == ab) ? fe : 0), $sformatf("R8 %s err_eng c=%0d", tg, c),
                int'(err_eng), (c == ab) ? fe : 0);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < N_ENG; i++) dly[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req == '0 && !gbl && !done && !err && err_eng == '0, "R1 outputs in reset",
            int'({req, gbl, done, err, err_eng}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req == '0 && !gbl && !done && !err, "R1 idle after reset", int'({req, gbl, done, err}), 0);

        // R3: delay sweep per engine across the timeout boundary
        for (int e = 0; e < N_ENG; e++) begin
            for (int d = 0; d <= TMO + 1; d++) begin
                run_seq((e == 0) ? d : 0, (e == 1) ? d : 0, (e == 2) ? d : 0, 1'b0, "R3 sweep");
            end
        end
        // R6: engine that never answers, at each position
        run_seq(NEVER, 0, 0, 1'b0, "R6 never0");
        run_seq(2, NEVER, 0, 1'b0, "R6 never1");
        run_seq(TMO - 1, TMO - 1, NEVER, 1'b0, "R6 never2");
        // R3: all engines at the last accepted sample
        run_seq(TMO - 1, TMO - 1, TMO - 1, 1'b0, "R3 all last");
        run_seq(1, 3, 2, 1'b0, "R2 mixed");
        // R7: start repeated mid-sequence is ignored
        run_seq(0, 0, 0, 1'b1, "R7 restart ok");
        run_seq(3, TMO, 0, 1'b1, "R7 restart err");

        // R1: reset in the middle of a sequence
        dly[0] = NEVER;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (3) @(negedge clk);
        chk(req[0] == 1'b1, "R2 request raised before mid reset", int'(req[0]), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(req == '0 && !gbl && !done && !err, "R1 mid-run reset clears", int'({req, gbl, done, err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_seq(0, 1, 0, 1'b0, "R1 after mid reset");

        summary();
        $finish;
    end
endmodule